// File: doc/BRIEF.md
# UART Interrupt Priority Controller

This block decides, for one serial channel, whether an interrupt is raised and which cause software sees first. Four cause inputs arrive as level signals from the surrounding channel logic. They are a line-error condition, the receive-buffer fill compared against a trigger threshold, a receive timeout, and a modem-line change. A fifth cause, "transmit holding empty", is tracked internally from the transmitter's empty flag. A small register port gives access to an enable register, with one bit per cause, and to a status register. The status register reports only the single most urgent enabled cause as a 3-bit code, together with a "nothing pending" flag.

Reading the status register has a side effect. When the returned code is the transmit-empty cause, that cause is acknowledged and dropped. Writing a new character into the transmitter also drops it. The transmit-empty cause arms again on a fresh rising edge of the empty flag, and also when software turns its enable bit on while the transmitter is already empty. With every enable bit at zero the channel runs polled: software inspects its line status directly and no interrupt is raised.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous reset the enable register reads 0, a status read returns 0x01 and `irq` is low.
- R2: Status read data: bit 0 is 1 exactly when no enabled cause is pending. Bits 3:1 hold the cause code: line error 011, receive data 010, receive timeout 110, transmit empty 001, modem change 000. Bits above 3 read 0.
- R3: Only the most urgent pending enabled cause is reported, in the order line error > receive (data or timeout) > transmit empty > modem change. A lower cause becomes visible only after every higher one has cleared.
- R4: With enable bit 0 set, the receive cause is pending while `rx_level >= rx_thresh` (code 010) or while `rx_timeout` is high (code 110 when the level is below threshold). It vanishes once the level drops below the threshold and no timeout is present.
- R5: A rising edge of `tx_empty` arms the transmit-empty cause. A status read that returns code 001 clears it.
- R6: A `thr_load` pulse clears the transmit-empty cause.
- R7: Writing enable bit 1 from 0 to 1 while `tx_empty` is high arms the transmit-empty cause. Doing the same while `tx_empty` is low does not.
- R8: Enable bit positions: 0 receive, 1 transmit empty, 2 line error, 3 modem change. A cause whose bit is 0 never appears in status and never raises `irq`.
- R9: `irq` is registered. It is high in the cycle after any enabled cause is pending and low in the cycle after none is.
- R10: With the enable register at 0 (polled mode), `irq` stays low and status reads 0x01 even when every cause input is active.
- R11: Reading the enable register returns the last written bits 3:0, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the status register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data, valid the cycle after `reg_rd` |
| line_err | input | 1 | Line-error cause (level) |
| rx_level | input | CNT_W | Current receive-buffer fill |
| rx_thresh | input | CNT_W | Receive trigger threshold |
| rx_timeout | input | 1 | Receive timeout cause (level) |
| tx_empty | input | 1 | Transmit holding register empty flag |
| thr_load | input | 1 | Pulse: a character was written to the transmitter |
| modem_chg | input | 1 | Modem-line change cause (level) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the default DATA_W of 8 and CNT_W of 5. This lets the receive fill run from 0 to 16, so the threshold comparison can be hit exactly at, one below and one above a threshold of 4. The 8-bit read data also shows that the upper status and enable bits read as zero. All four causes are driven at once and then removed one by one, which walks the full priority order. The transmit-empty cause is armed by both an edge and an enable write, and cleared by both a status read and a load pulse.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 4;

  // pending-vector index: lower index is more urgent
  localparam int IDX_LINE  = 0;
  localparam int IDX_RX    = 1;
  localparam int IDX_TX    = 2;
  localparam int IDX_MODEM = 3;

  // enable register bit positions
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef enum logic [2:0] {
    CAUSE_MODEM = 3'b000,
    CAUSE_TXE   = 3'b001,
    CAUSE_RXD   = 3'b010,
    CAUSE_LINE  = 3'b011,
    CAUSE_RXTO  = 3'b110
  } cause_e;
endpackage

// File: rtl/uirq_txe_latch.sv
module uirq_txe_latch (
  input  logic clk,
  input  logic rst,
  input  logic tx_empty,
  input  logic rearm,
  input  logic thr_load,
  input  logic rd_ack,
  output logic pend
);
  logic empty_q;
  logic rise;

  assign rise = tx_empty & ~empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      pend    <= 1'b0;
    end else begin
      empty_q <= tx_empty;
      if (thr_load)
        pend <= 1'b0;
      else if (rise || (rearm && tx_empty))
        pend <= 1'b1;
      else if (rd_ack)
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic            rx_data,
  output logic            none,
  output cause_e          cause
);
  function automatic cause_e code_of(input int idx, input logic rxd);
    case (idx)
      IDX_LINE: code_of = CAUSE_LINE;
      IDX_RX:   code_of = rxd ? CAUSE_RXD : CAUSE_RXTO;
      IDX_TX:   code_of = CAUSE_TXE;
      default:  code_of = CAUSE_MODEM;
    endcase
  endfunction

  always_comb begin
    none  = 1'b1;
    cause = CAUSE_MODEM;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        none  = 1'b0;
        cause = code_of(i, rx_data);
      end
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              line_err,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  rx_thresh,
  input  logic              rx_timeout,
  input  logic              tx_empty,
  input  logic              thr_load,
  input  logic              modem_chg,
  output logic              irq
);
  localparam int PADW = DATA_W - NSRC;

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] pend;
  logic            tx_pend;
  logic            rx_data;
  logic            none;
  cause_e          cause;
  logic            rearm;
  logic            rd_ack;
  logic [NSRC-1:0] stat_nib;

  assign rx_data = (rx_level >= rx_thresh);
  assign rearm   = reg_wr & ~reg_sel & reg_wdata[EN_TX] & ~en_q[EN_TX];
  assign rd_ack  = reg_rd & reg_sel & ~none & (cause == CAUSE_TXE);

  assign pend[IDX_LINE]  = en_q[EN_LINE]  & line_err;
  assign pend[IDX_RX]    = en_q[EN_RX]    & (rx_data | rx_timeout);
  assign pend[IDX_TX]    = en_q[EN_TX]    & tx_pend;
  assign pend[IDX_MODEM] = en_q[EN_MODEM] & modem_chg;

  uirq_txe_latch u_txe (
    .clk      (clk),
    .rst      (rst),
    .tx_empty (tx_empty),
    .rearm    (rearm),
    .thr_load (thr_load),
    .rd_ack   (rd_ack),
    .pend     (tx_pend)
  );

  uirq_prio_enc u_enc (
    .pend    (pend),
    .rx_data (rx_data),
    .none    (none),
    .cause   (cause)
  );

  assign stat_nib = {cause, none};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= |pend;
      if (reg_wr && !reg_sel)
        en_q <= reg_wdata[NSRC-1:0];
      if (reg_rd)
        reg_rdata <= reg_sel ? {{PADW{1'b0}}, stat_nib}
                             : {{PADW{1'b0}}, en_q};
    end
  end
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [CNT_W-1:0]  rx_level,
  input logic [CNT_W-1:0]  rx_thresh,
  input logic              rx_timeout,
  input logic              line_err,
  input logic              modem_chg,
  input logic              tx_empty,
  input logic              thr_load,
  input logic [3:0]        en_q,
  input logic              tx_pend,
  input logic              irq
);
  logic any_cause;
  assign any_cause = (en_q[2] & line_err)
                   | (en_q[0] & ((rx_level >= rx_thresh) | rx_timeout))
                   | (en_q[1] & tx_pend)
                   | (en_q[3] & modem_chg);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !irq);

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    any_cause |=> irq);

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !any_cause |=> !irq);

  p_polled_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (en_q == 4'd0) |=> !irq);

  p_load_clears_r6: assert property (@(posedge clk) disable iff (rst)
    thr_load |=> !tx_pend);

  p_rearm_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && reg_wdata[1] && !en_q[1] && tx_empty && !thr_load)
      |=> tx_pend);
endmodule

bind uart_irq_ctrl uirq_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .rx_level   (rx_level),
  .rx_thresh  (rx_thresh),
  .rx_timeout (rx_timeout),
  .line_err   (line_err),
  .modem_chg  (modem_chg),
  .tx_empty   (tx_empty),
  .thr_load   (thr_load),
  .en_q       (en_q),
  .tx_pend    (tx_pend),
  .irq        (irq)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              line_err = 1'b0, rx_timeout = 1'b0, modem_chg = 1'b0;
  logic [CNT_W-1:0]  rx_level = '0, rx_thresh = 5'd4;
  logic              tx_empty = 1'b1, thr_load = 1'b0;
  logic              irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_err(line_err),
    .rx_level(rx_level), .rx_thresh(rx_thresh), .rx_timeout(rx_timeout),
    .tx_empty(tx_empty), .thr_load(thr_load), .modem_chg(modem_chg), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_reg(input logic sel, output logic [DATA_W-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic chk_status(input string req, input logic [7:0] exp);
    logic [DATA_W-1:0] d;
    rd_reg(1'b1, d);
    chk(req, d, exp);
  endtask

  task automatic wr_en(input logic [DATA_W-1:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic load_pulse();
    @(negedge clk); thr_load = 1'b1;
    @(negedge clk); thr_load = 1'b0;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    chk("R1 irq", irq, 0);
    chk_status("R1 R2 status idle", 8'h01);
    rd_reg(1'b0, d);
    chk("R1 enable", d, 0);
  endtask

  task automatic t_readback();
    logic [DATA_W-1:0] d;
    wr_en(8'hF5);
    rd_reg(1'b0, d);
    chk("R11 enable readback", d, 8'h05);
    wr_en(8'h00);
  endtask

  task automatic t_polled();
    @(negedge clk); line_err = 1; rx_level = 8; rx_timeout = 1; modem_chg = 1; tx_empty = 0;
    @(negedge clk); tx_empty = 1;
    wait_n(2);
    chk("R10 irq polled", irq, 0);
    chk_status("R10 status polled", 8'h01);
    @(negedge clk); line_err = 0; rx_level = 0; rx_timeout = 0; modem_chg = 0;
    load_pulse();
  endtask

  task automatic t_rx();
    wr_en(8'h01);
    @(negedge clk); rx_level = 3;
    wait_n(1);
    chk("R4 R9 irq below thresh", irq, 0);
    chk_status("R4 below thresh", 8'h01);
    @(negedge clk); rx_level = 4;
    wait_n(1);
    chk("R9 irq at thresh", irq, 1);
    chk_status("R4 R2 at thresh", 8'h04);
    @(negedge clk); rx_level = 3;
    wait_n(1);
    chk("R9 irq dropped", irq, 0);
    @(negedge clk); rx_timeout = 1;
    chk_status("R4 timeout code", 8'h0C);
    @(negedge clk); rx_level = 5;
    chk_status("R4 data over timeout", 8'h04);
    @(negedge clk); rx_level = 0; rx_timeout = 0;
    wr_en(8'h00);
  endtask

  task automatic t_tx();
    @(negedge clk); tx_empty = 0;
    wr_en(8'h02);
    chk_status("R7 no rearm when busy", 8'h01);
    @(negedge clk); tx_empty = 1;
    wait_n(2);
    chk("R5 R9 irq tx", irq, 1);
    chk_status("R5 tx code", 8'h02);
    chk_status("R5 read cleared", 8'h01);
    wait_n(1);
    chk("R5 irq after ack", irq, 0);
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1;
    wait_n(1);
    chk_status("R5 edge rearmed", 8'h02);
    chk_status("R5 read cleared again", 8'h01);
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1;
    load_pulse();
    chk_status("R6 load cleared", 8'h01);
  endtask

  task automatic t_rearm();
    wr_en(8'h00);
    wr_en(8'h02);
    chk_status("R7 rearm on enable", 8'h02);
    chk_status("R7 cleared", 8'h01);
  endtask

  task automatic t_prio();
    wr_en(8'h0F);
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1; line_err = 1; rx_level = 5; modem_chg = 1;
    wait_n(1);
    chk_status("R3 line first", 8'h06);
    @(negedge clk); line_err = 0;
    chk_status("R3 rx second", 8'h04);
    @(negedge clk); rx_level = 0;
    chk_status("R3 tx third", 8'h02);
    chk_status("R3 modem last", 8'h00);
    @(negedge clk); modem_chg = 0;
    chk_status("R3 all clear", 8'h01);
    wait_n(1);
    chk("R9 irq idle", irq, 0);
  endtask

  task automatic t_mask();
    wr_en(8'h04);
    @(negedge clk); rx_level = 9; modem_chg = 1;
    wait_n(1);
    chk("R8 irq masked", irq, 0);
    chk_status("R8 rx modem masked", 8'h01);
    @(negedge clk); line_err = 1;
    chk_status("R8 line enabled", 8'h06);
    wr_en(8'h08);
    chk_status("R8 line rx masked", 8'h00);
    @(negedge clk); modem_chg = 0;
    chk_status("R8 modem gone", 8'h01);
    @(negedge clk); line_err = 0; rx_level = 0;
    wr_en(8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_readback();
    t_polled();
    t_rx();
    t_tx();
    t_rearm();
    t_prio();
    t_mask();
    wait_n(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule